// File: doc/BRIEF.md
# System-Control Port Bank

A byte-wide bank of legacy platform I/O ports on a simple synchronous access bus. A single port holds the soft-reset level and the byte-order flag. A window of board registers returns fixed identification bytes. Writable fields drive the disk-activity lamp, a 4-bit cache-control field and the address-map selection. Writes to two lock ports each produce a single-cycle toggle pulse for a nonvolatile-memory lock level. Two scratch bytes can be read and written freely. Every read of a port that nothing decodes returns all ones.

The block also translates a CPU I/O-window offset into a bus port address. The stored map-mode bit chooses between a flat 64 KB space and a sparse 8 MB space. In the sparse space each 4 KB page carries 32 ports. Accesses take one cycle. Read data is registered and comes back one clock after the request, marked by a valid strobe.

Top module: `sysport_ctrl`

## Requirements
- R1: A write to port 0x0092 sets `soft_rst` to data bit 0 and `little_endian` to data bit 1. Both levels hold until the next write to that port. A read of 0x0092 returns 0x00.
- R2: Reads of 0x0800, 0x0802 and 0x0803 return 0xEF, 0xAD and 0xE0. Writes to these ports change no output and no later read value.
- R3: Reads of 0x080C, 0x0810, 0x0818 and 0x0823 return 0x3C, 0x39, 0x00 and 0x03.
- R4: A write to 0x0808 sets `disk_led` to data bit 0.
- R5: A write to 0x081C stores data bits 3:0 in `cache_ctl`. A read of 0x081C returns that value in bits 3:0, with bits 7:4 zero.
- R6: A write to 0x0810 drives `lock1_tgl` high for exactly the one cycle after the write. A write to 0x0812 does the same for `lock2_tgl`. A write to 0x0814 changes no output.
- R7: A write to 0x0850 sets `map_mode` to data bit 0. A read of 0x0850 returns that bit in bit 0, with the other bits zero.
- R8: With `map_mode` 0, `win_port` equals `win_addr[15:0]`. With `map_mode` 1, `win_port` equals `{win_addr[22:12], win_addr[4:0]}`.
- R9: A read of any port that is not decoded returns 0xFF. This includes 0x0814 and the gaps inside 0x0800 to 0x0851.
- R10: Ports 0x0398 and 0x0399 are two independent read/write scratch bytes.
- R11: After reset, every stored field and both scratch bytes read 0. All outputs are 0, which selects the flat map.
- R12: `rd_valid` is high in exactly the cycle after each read request, and `rd_data` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Port address |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data strobe |
| win_addr | input | 23 | CPU I/O-window offset |
| win_port | output | 16 | Translated port address |
| soft_rst | output | 1 | Soft-reset level |
| little_endian | output | 1 | Byte-order flag |
| disk_led | output | 1 | Disk-activity lamp |
| cache_ctl | output | 4 | Cache-control field |
| map_mode | output | 1 | 0 = flat map, 1 = sparse map |
| lock1_tgl | output | 1 | Lock level 1 toggle pulse |
| lock2_tgl | output | 1 | Lock level 2 toggle pulse |

## Verification
The bench targets the places where this block's ports overlap. Port 0x0810 reads a constant but pulses a lock on write, so a decoder that shares read and write decode would return the written byte or miss the pulse. A write of 0xFF to 0x081C catches a design that stores the high nibble. Writes to the identification ports and to 0x0814 catch a design that spills data into a neighbouring field. Translation is checked in both map modes with offsets whose middle bits 11:5 are nonzero, so a sparse map that keeps those bits, or the wrong shift, gives the wrong port.

// File: rtl/sysport_pkg.sv
package sysport_pkg;
   localparam int unsigned PORT_W = 16;
   localparam int unsigned BYTE_W = 8;

   localparam logic [PORT_W-1:0] P_SYSCTL   = 16'h0092;
   localparam logic [PORT_W-1:0] P_CPUCFG   = 16'h0800;
   localparam logic [PORT_W-1:0] P_FEAT     = 16'h0802;
   localparam logic [PORT_W-1:0] P_STAT     = 16'h0803;
   localparam logic [PORT_W-1:0] P_LAMP     = 16'h0808;
   localparam logic [PORT_W-1:0] P_EQUIP    = 16'h080C;
   localparam logic [PORT_W-1:0] P_LOCK1    = 16'h0810;
   localparam logic [PORT_W-1:0] P_LOCK2    = 16'h0812;
   localparam logic [PORT_W-1:0] P_CINV     = 16'h0814;
   localparam logic [PORT_W-1:0] P_KEY      = 16'h0818;
   localparam logic [PORT_W-1:0] P_CACHE    = 16'h081C;
   localparam logic [PORT_W-1:0] P_L2ID     = 16'h0823;
   localparam logic [PORT_W-1:0] P_MAPSEL   = 16'h0850;

   localparam logic [BYTE_W-1:0] V_CPUCFG = 8'hEF;
   localparam logic [BYTE_W-1:0] V_FEAT   = 8'hAD;
   localparam logic [BYTE_W-1:0] V_STAT   = 8'hE0;
   localparam logic [BYTE_W-1:0] V_EQUIP  = 8'h3C;
   localparam logic [BYTE_W-1:0] V_XFEAT  = 8'h39;
   localparam logic [BYTE_W-1:0] V_KEY    = 8'h00;
   localparam logic [BYTE_W-1:0] V_L2ID   = 8'h03;
   localparam logic [BYTE_W-1:0] V_NONE   = 8'hFF;

   typedef enum logic {MAP_FLAT = 1'b0, MAP_SPARSE = 1'b1} map_e;
endpackage

// File: rtl/sysport_xlat.sv
module sysport_xlat #(
   parameter int unsigned WIN_AW  = 23,
   parameter int unsigned PORT_AW = 16,
   parameter int unsigned LOW_W   = 5,
   parameter int unsigned PAGE_LSB = 12
) (
   input  logic               map_mode,
   input  logic [WIN_AW-1:0]  win_addr,
   output logic [PORT_AW-1:0] win_port
);
   import sysport_pkg::*;

   localparam int unsigned HI_W = PORT_AW - LOW_W;

   generate
      if (PAGE_LSB + HI_W > WIN_AW) begin : g_bad_width
         $error("sysport_xlat: window too narrow for sparse map");
      end
   endgenerate

   logic [PORT_AW-1:0] flat_port;
   logic [PORT_AW-1:0] sparse_port;

   assign flat_port   = win_addr[PORT_AW-1:0];
   assign sparse_port = {win_addr[PAGE_LSB+HI_W-1:PAGE_LSB], win_addr[LOW_W-1:0]};

   always_comb begin
      if (map_e'(map_mode) == MAP_SPARSE) win_port = sparse_port;
      else                                win_port = flat_port;
   end

   always_comb begin
      if (map_mode)
         AST_SPARSE_LOW: assert (win_port[LOW_W-1:0] == win_addr[LOW_W-1:0]); // R8
   end
endmodule

// File: rtl/sysport_regs.sv
module sysport_regs #(
   parameter int unsigned PORT_AW   = 16,
   parameter int unsigned DW        = 8,
   parameter int unsigned CW        = 4,
   parameter int unsigned SCRATCH_N = 2,
   parameter logic [15:0] SCRATCH_BASE = 16'h0398
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [PORT_AW-1:0]            wr_addr,
   input  logic [DW-1:0]                 wr_data,
   output logic                          soft_rst,
   output logic                          little_endian,
   output logic                          disk_led,
   output logic [CW-1:0]                 cache_ctl,
   output logic                          map_mode,
   output logic                          lock1_tgl,
   output logic                          lock2_tgl,
   output logic [SCRATCH_N-1:0][DW-1:0]  scratch
);
   import sysport_pkg::*;

   generate
      if (CW > DW) begin : g_bad_cw
         $error("sysport_regs: cache field wider than data");
      end
      if (DW < 2) begin : g_bad_dw
         $error("sysport_regs: data must carry two control bits");
      end
   endgenerate

   logic hit_sys, hit_lamp, hit_cache, hit_map, hit_l1, hit_l2;
   assign hit_sys   = wr_en && (wr_addr == P_SYSCTL);
   assign hit_lamp  = wr_en && (wr_addr == P_LAMP);
   assign hit_cache = wr_en && (wr_addr == P_CACHE);
   assign hit_map   = wr_en && (wr_addr == P_MAPSEL);
   assign hit_l1    = wr_en && (wr_addr == P_LOCK1);
   assign hit_l2    = wr_en && (wr_addr == P_LOCK2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         soft_rst      <= 1'b0;
         little_endian <= 1'b0;
         disk_led      <= 1'b0;
         cache_ctl     <= '0;
         map_mode      <= 1'b0;
         lock1_tgl     <= 1'b0;
         lock2_tgl     <= 1'b0;
      end else begin
         lock1_tgl <= hit_l1;
         lock2_tgl <= hit_l2;
         if (hit_sys) begin
            soft_rst      <= wr_data[0];
            little_endian <= wr_data[1];
         end
         if (hit_lamp)  disk_led  <= wr_data[0];
         if (hit_cache) cache_ctl <= wr_data[CW-1:0];
         if (hit_map)   map_mode  <= wr_data[0];
      end
   end

   for (genvar i = 0; i < SCRATCH_N; i++) begin : g_scr
      logic hit;
      assign hit = wr_en && (wr_addr == PORT_AW'(SCRATCH_BASE + i));
      always_ff @(posedge clk) begin
         if (!rst_n)   scratch[i] <= '0;
         else if (hit) scratch[i] <= wr_data;
      end
   end

   AST_LOCK1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      lock1_tgl |-> $past(wr_en && wr_addr == P_LOCK1)); // R6
   AST_LOCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lock1_tgl, lock2_tgl})); // R6
   AST_CACHE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == P_CACHE) |=> $stable(cache_ctl)); // R5
   AST_SYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == P_SYSCTL) |=> $stable({soft_rst, little_endian})); // R1
endmodule

// File: rtl/sysport_rdmux.sv
module sysport_rdmux #(
   parameter int unsigned PORT_AW   = 16,
   parameter int unsigned DW        = 8,
   parameter int unsigned CW        = 4,
   parameter int unsigned SCRATCH_N = 2,
   parameter logic [15:0] SCRATCH_BASE = 16'h0398
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rd_en,
   input  logic [PORT_AW-1:0]            rd_addr,
   input  logic [CW-1:0]                 cache_ctl,
   input  logic                          map_mode,
   input  logic [SCRATCH_N-1:0][DW-1:0]  scratch,
   output logic [DW-1:0]                 rd_data,
   output logic                          rd_valid
);
   import sysport_pkg::*;

   logic [DW-1:0] fixed_val;
   logic [DW-1:0] scr_val;
   logic          scr_hit;
   logic [DW-1:0] next_val;

   always_comb begin
      unique case (rd_addr)
         P_SYSCTL: fixed_val = '0;
         P_CPUCFG: fixed_val = V_CPUCFG;
         P_FEAT:   fixed_val = V_FEAT;
         P_STAT:   fixed_val = V_STAT;
         P_EQUIP:  fixed_val = V_EQUIP;
         P_LOCK1:  fixed_val = V_XFEAT;
         P_KEY:    fixed_val = V_KEY;
         P_L2ID:   fixed_val = V_L2ID;
         P_CACHE:  fixed_val = DW'(cache_ctl);
         P_MAPSEL: fixed_val = DW'(map_mode);
         default:  fixed_val = V_NONE;
      endcase
   end

   always_comb begin
      scr_hit = 1'b0;
      scr_val = '0;
      for (int i = 0; i < SCRATCH_N; i++) begin
         if (rd_addr == PORT_AW'(SCRATCH_BASE + i)) begin
            scr_hit = 1'b1;
            scr_val = scratch[i];
         end
      end
   end

   assign next_val = scr_hit ? scr_val : fixed_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= next_val;
      end
   end

   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid); // R12
   AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && rd_addr == P_CPUCFG |=> rd_data == V_CPUCFG); // R2
   AST_HOLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && rd_addr == P_CINV |=> rd_data == V_NONE); // R9
endmodule

// File: rtl/sysport_ctrl.sv
module sysport_ctrl #(
   parameter int unsigned PORT_AW   = 16,
   parameter int unsigned WIN_AW    = 23,
   parameter int unsigned DW        = 8,
   parameter int unsigned CW        = 4,
   parameter int unsigned SCRATCH_N = 2,
   parameter logic [15:0] SCRATCH_BASE = 16'h0398
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic [PORT_AW-1:0] acc_addr,
   input  logic [DW-1:0]      acc_wdata,
   output logic [DW-1:0]      rd_data,
   output logic               rd_valid,
   input  logic [WIN_AW-1:0]  win_addr,
   output logic [PORT_AW-1:0] win_port,
   output logic               soft_rst,
   output logic               little_endian,
   output logic               disk_led,
   output logic [CW-1:0]      cache_ctl,
   output logic               map_mode,
   output logic               lock1_tgl,
   output logic               lock2_tgl
);
   generate
      if (PORT_AW != 16) begin : g_bad_port
         $error("sysport_ctrl: port space must be 16 bits");
      end
      if (SCRATCH_N == 0) begin : g_bad_scr
         $error("sysport_ctrl: at least one scratch byte");
      end
   endgenerate

   logic wr_en, rd_en;
   logic [SCRATCH_N-1:0][DW-1:0] scratch;

   assign wr_en = acc_valid &&  acc_write;
   assign rd_en = acc_valid && !acc_write;

   sysport_regs #(
      .PORT_AW(PORT_AW), .DW(DW), .CW(CW),
      .SCRATCH_N(SCRATCH_N), .SCRATCH_BASE(SCRATCH_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(acc_addr), .wr_data(acc_wdata),
      .soft_rst(soft_rst), .little_endian(little_endian), .disk_led(disk_led),
      .cache_ctl(cache_ctl), .map_mode(map_mode),
      .lock1_tgl(lock1_tgl), .lock2_tgl(lock2_tgl), .scratch(scratch)
   );

   sysport_rdmux #(
      .PORT_AW(PORT_AW), .DW(DW), .CW(CW),
      .SCRATCH_N(SCRATCH_N), .SCRATCH_BASE(SCRATCH_BASE)
   ) u_rdmux (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_en), .rd_addr(acc_addr),
      .cache_ctl(cache_ctl), .map_mode(map_mode), .scratch(scratch),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   sysport_xlat #(
      .WIN_AW(WIN_AW), .PORT_AW(PORT_AW)
   ) u_xlat (
      .map_mode(map_mode), .win_addr(win_addr), .win_port(win_port)
   );

   AST_MAP_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !acc_write && acc_addr == 16'h0850 |=> rd_data == DW'(map_mode)); // R7
endmodule

// File: tb/sysport_ctrl_bench.sv
module sysport_ctrl_bench;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [15:0] acc_addr = '0;
   logic [7:0]  acc_wdata = '0;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic [22:0] win_addr = '0;
   logic [15:0] win_port;
   logic        soft_rst, little_endian, disk_led, map_mode, lock1_tgl, lock2_tgl;
   logic [3:0]  cache_ctl;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   logic [7:0] q_exp[$];
   string      q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sysport_ctrl u_sysport_ctrl (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .rd_data(rd_data), .rd_valid(rd_valid),
      .win_addr(win_addr), .win_port(win_port),
      .soft_rst(soft_rst), .little_endian(little_endian), .disk_led(disk_led),
      .cache_ctl(cache_ctl), .map_mode(map_mode),
      .lock1_tgl(lock1_tgl), .lock2_tgl(lock2_tgl)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
      q_exp.push_back(exp);
      q_tag.push_back(tag);
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   // monitor: pops one expected byte per rd_valid (R12)
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (q_exp.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R12: actual unexpected read data 0x%0h expected no data", rd_data);
         end else begin
            check(q_tag.pop_front(), {24'd0, rd_data}, {24'd0, q_exp.pop_front()});
         end
      end
   end

   function automatic logic [15:0] sparse(input logic [22:0] a);
      logic [31:0] w;
      w = {9'd0, a};
      return 16'((w & 32'h1F) | ((w & 32'h007F_F000) >> 7));
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL R12: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 outputs", {soft_rst, little_endian, disk_led, cache_ctl, map_mode, lock1_tgl, lock2_tgl, rd_valid}, '0);
      rd(16'h0398, 8'h00, "R11 scratch0");
      rd(16'h0399, 8'h00, "R11 scratch1");
      rd(16'h081C, 8'h00, "R11 cache");
      rd(16'h0850, 8'h00, "R11 map");

      // R2 and R3 identification bytes
      rd(16'h0800, 8'hEF, "R2 cpucfg");
      rd(16'h0802, 8'hAD, "R2 feat");
      rd(16'h0803, 8'hE0, "R2 stat");
      rd(16'h080C, 8'h3C, "R3 equip");
      rd(16'h0810, 8'h39, "R3 xfeat");
      rd(16'h0818, 8'h00, "R3 key");
      rd(16'h0823, 8'h03, "R3 l2id");

      // R9 undecoded
      rd(16'h0801, 8'hFF, "R9 hole 0801");
      rd(16'h0814, 8'hFF, "R9 hole 0814");
      rd(16'h0851, 8'hFF, "R9 hole 0851");
      rd(16'h1234, 8'hFF, "R9 outside");

      // R1 port 0x0092
      wr(16'h0092, 8'h01);
      check("R1 soft_rst set", {soft_rst, little_endian}, 2'b10);
      repeat (3) @(negedge clk);
      check("R1 soft_rst held", {soft_rst, little_endian}, 2'b10);
      wr(16'h0092, 8'hFE);
      check("R1 endian only", {soft_rst, little_endian}, 2'b01);
      rd(16'h0092, 8'h00, "R1 read");

      // R2 writes ignored
      wr(16'h0800, 8'h00);
      wr(16'h0802, 8'hFF);
      wr(16'h0803, 8'h5A);
      check("R2 no side effect", {soft_rst, little_endian, disk_led, cache_ctl, map_mode}, 8'b01_0_0000_0);
      rd(16'h0800, 8'hEF, "R2 cpucfg after write");
      rd(16'h0803, 8'hE0, "R2 stat after write");

      // R4 lamp
      wr(16'h0808, 8'h03);
      check("R4 led on", disk_led, 1);
      wr(16'h0808, 8'hFE);
      check("R4 led off", disk_led, 0);

      // R5 cache field
      wr(16'h081C, 8'hFF);
      check("R5 cache low nibble", cache_ctl, 4'hF);
      rd(16'h081C, 8'h0F, "R5 readback FF");
      wr(16'h081C, 8'hA6);
      rd(16'h081C, 8'h06, "R5 readback A6");

      // R6 lock pulses
      wr(16'h0810, 8'h00);
      check("R6 lock1 high", {lock1_tgl, lock2_tgl}, 2'b10);
      @(negedge clk);
      check("R6 lock1 one cycle", {lock1_tgl, lock2_tgl}, 2'b00);
      wr(16'h0812, 8'h55);
      check("R6 lock2 high", {lock1_tgl, lock2_tgl}, 2'b01);
      @(negedge clk);
      check("R6 lock2 one cycle", {lock1_tgl, lock2_tgl}, 2'b00);
      rd(16'h0810, 8'h39, "R6 lock1 port reads constant");
      wr(16'h0814, 8'hFF);
      check("R6 0814 no effect", {soft_rst, little_endian, disk_led, cache_ctl, map_mode, lock1_tgl, lock2_tgl}, 10'b01_0_0110_0_00);

      // R10 scratch
      wr(16'h0398, 8'hC3);
      wr(16'h0399, 8'h5A);
      rd(16'h0398, 8'hC3, "R10 scratch0");
      rd(16'h0399, 8'h5A, "R10 scratch1");

      // R8 translation, flat
      win_addr = 23'h5A_B3C7;
      #1 check("R8 flat", win_port, 16'hB3C7);
      // R7 map mode
      wr(16'h0850, 8'hFF);
      check("R7 map set", map_mode, 1);
      rd(16'h0850, 8'h01, "R7 readback");
      win_addr = 23'h5A_B3C7;
      #1 check("R8 sparse a", win_port, sparse(23'h5A_B3C7));
      win_addr = 23'h7F_FFE0;
      #1 check("R8 sparse b", win_port, sparse(23'h7F_FFE0));
      wr(16'h0850, 8'h02);
      check("R7 map clear", map_mode, 0);
      #1 check("R8 flat again", win_port, 16'hFFE0);

      repeat (3) @(negedge clk);
      check("R12 queue drained", q_exp.size(), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule